// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the host-facing digital port of a measurement converter. A host talks to it over a four-wire serial link: a serial clock, an active-low select, a data input and a data output. The block holds an 8-bit command register, an 8-bit setup register, an 8-bit clock-control register and a 16-bit result register that is read-only. Each access starts with one byte written to the command register. Its select field picks the register for the next transfer, and its direction bit picks write or read. When that transfer ends, the port again expects a command byte.

The conversion core delivers results through a parallel word and a one-cycle strobe, and signals the end of calibration with a done pulse. The port drives an active-low ready flag from these events. The flag goes low when a fresh result is stored. It goes high after a complete 16-bit read of the result. If the host has not read a result before the next one arrives, the port holds the flag high for a fixed window of master-clock cycles, and only then stores the new word. A read taken during that window returns the old result.

The serial clock and the select line are synchronised into the master clock domain before their edges are detected. The select line may be tied low for three-wire use, or toggled to frame transfers.

Top module: `conv_serial_port`

## Requirements
- R1: A command byte is shifted in MSB first. Bits [5:4] select the target (0 command, 1 setup, 2 clock, 3 result), and bit 3 set means read. Reading the command register returns the command byte just written. After each transfer the port expects a new command byte.
- R2: A write to setup or clock takes the next 8 data-in bits, MSB first, and a later read returns the same value. Only a completed write to the clock register changes it.
- R3: Clock register bit 4 drives `clk_out_off`, and bits [2:0] drive `rate_sel`. The setup register drives `setup_cfg`.
- R4: A write aimed at the result register consumes 8 bits and is discarded. The stored result is unchanged, and the next byte is taken as a command.
- R5: A result strobe while `drdy_n` is high stores the word on the next edge and drives `drdy_n` low. `drdy_n` falls only on a result store or a calibration-done pulse.
- R6: Reading all 16 result bits drives `drdy_n` high. While `drdy_n` stays high, reading again returns the same word.
- R7: A result strobe while `drdy_n` is low raises `drdy_n` for exactly BLANK_CYCLES (default 500) master cycles. The new word is stored as `drdy_n` falls. Reads during the window return the previous word.
- R8: A calibration-done pulse drives `drdy_n` low and leaves the stored result unchanged.
- R9: Data-in is sampled on rising serial-clock edges. Data-out changes only after a falling edge.
- R10: Raising `cs_n` abandons any partial transfer without writing a register, and the next byte is taken as a command. With `cs_n` held low, transfers work back to back.
- R11: Reset drives `drdy_n` high and `dout` low, and clears every register and output field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle high |
| cs_n | input | 1 | Active-low select, frames transfers |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| drdy_n | output | 1 | Active-low result-ready flag |
| result | input | DATA_W | Conversion result word |
| result_stb | input | 1 | One-cycle strobe marking a new result |
| cal_done | input | 1 | One-cycle pulse at end of calibration |
| setup_cfg | output | REG_W | Setup register contents |
| clk_out_off | output | 1 | Clock-output disable field |
| rate_sel | output | 3 | Update-rate select field |

## Verification
A serial-clock edge reaches the registers three master cycles after the pin moves: two synchroniser flops, then one register. The bench therefore holds each half of the serial clock for five master cycles. It changes data-in on the falling half, and it samples data-out just before raising the clock. A result strobe or calibration pulse moves `drdy_n` on the very next edge, so the bench checks it two cycles later. A completed read releases the flag within three cycles of the last rising edge, and the bench checks it after the five-cycle hold. The blanking window is measured by counting falling master-clock edges on which `drdy_n` is high, from the strobe to the fall, and the count must equal exactly 500.

// File: rtl/csp_pkg.sv
package csp_pkg;
  typedef enum logic [1:0] {
    SEL_COMM  = 2'd0,
    SEL_SETUP = 2'd1,
    SEL_CLOCK = 2'd2,
    SEL_DATA  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  localparam int SEL_HI     = 5;
  localparam int SEL_LO     = 4;
  localparam int RD_BIT     = 3;
  localparam int CLKOFF_BIT = 4;
  localparam int RATE_W     = 3;
endpackage

// File: rtl/csp_sync_edge.sv
module csp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle
);
  logic [STAGES-1:0] sclk_sr, cs_sr;
  logic              sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr   <= '1;
      cs_sr     <= '1;
      sclk_prev <= 1'b1;
    end else begin
      sclk_sr   <= {sclk_sr[STAGES-2:0], sclk};
      cs_sr     <= {cs_sr[STAGES-2:0], cs_n};
      sclk_prev <= sclk_sr[STAGES-1];
    end
  end

  assign cs_idle   = cs_sr[STAGES-1];
  assign sclk_rise = !cs_idle &&  sclk_sr[STAGES-1] && !sclk_prev;
  assign sclk_fall = !cs_idle && !sclk_sr[STAGES-1] &&  sclk_prev;
endmodule

// File: rtl/csp_shifter.sv
module csp_shifter
  import csp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_idle,
  input  logic              din,
  input  logic [DATA_W-1:0] data_word,
  output logic              dout,
  output logic [REG_W-1:0]  setup_q,
  output logic [REG_W-1:0]  clk_reg,
  output logic              wr_stb,
  output logic [1:0]        wr_sel,
  output logic              rd_done
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int PAD_W = DATA_W - REG_W;

  phase_e             phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [REG_W-2:0]   isr_q, isr_n;
  logic [DATA_W-1:0]  osr_q, osr_n;
  logic               dout_q, dout_n;
  logic               fresh_q, fresh_n;
  logic [REG_W-1:0]   comm_q, comm_n, setup_n, clkr_q, clkr_n;
  logic [REG_W-1:0]   shifted;
  logic [DATA_W-1:0]  rd_word;
  logic [CNT_W-1:0]   rd_last;
  reg_sel_e           sel;

  assign sel     = reg_sel_e'(comm_q[SEL_HI:SEL_LO]);
  assign shifted = {isr_q, din};
  assign rd_last = (sel == SEL_DATA) ? CNT_W'(DATA_W - 1) : CNT_W'(REG_W - 1);

  always_comb begin
    case (sel)
      SEL_COMM:  rd_word = DATA_W'(comm_q)  << PAD_W;
      SEL_SETUP: rd_word = DATA_W'(setup_q) << PAD_W;
      SEL_CLOCK: rd_word = DATA_W'(clkr_q)  << PAD_W;
      default:   rd_word = data_word;
    endcase
  end

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    isr_n   = isr_q;
    osr_n   = osr_q;
    dout_n  = dout_q;
    fresh_n = fresh_q;
    comm_n  = comm_q;
    setup_n = setup_q;
    clkr_n  = clkr_q;
    wr_stb  = 1'b0;
    rd_done = 1'b0;
    if (cs_idle) begin
      phase_n = PH_CMD;
      cnt_n   = '0;
    end else if (sclk_fall && phase_q == PH_RD) begin
      if (fresh_q) begin
        dout_n  = rd_word[DATA_W-1];
        osr_n   = rd_word << 1;
        fresh_n = 1'b0;
      end else begin
        dout_n = osr_q[DATA_W-1];
        osr_n  = osr_q << 1;
      end
    end else if (sclk_rise) begin
      if (phase_q == PH_RD) begin
        cnt_n = cnt_q + CNT_W'(1);
        if (cnt_q == rd_last) begin
          cnt_n   = '0;
          phase_n = PH_CMD;
          rd_done = (sel == SEL_DATA);
        end
      end else begin
        isr_n = shifted[REG_W-2:0];
        cnt_n = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(REG_W - 1)) begin
          cnt_n = '0;
          if (phase_q == PH_CMD) begin
            comm_n  = shifted;
            fresh_n = 1'b1;
            phase_n = shifted[RD_BIT] ? PH_RD : PH_WR;
          end else begin
            wr_stb  = 1'b1;
            phase_n = PH_CMD;
            case (sel)
              SEL_COMM:  comm_n  = shifted;
              SEL_SETUP: setup_n = shifted;
              SEL_CLOCK: clkr_n  = shifted;
              default:   ;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      isr_q   <= '0;
      osr_q   <= '0;
      dout_q  <= 1'b0;
      fresh_q <= 1'b0;
      comm_q  <= '0;
      setup_q <= '0;
      clkr_q  <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      isr_q   <= isr_n;
      osr_q   <= osr_n;
      dout_q  <= dout_n;
      fresh_q <= fresh_n;
      comm_q  <= comm_n;
      setup_q <= setup_n;
      clkr_q  <= clkr_n;
    end
  end

  assign dout    = dout_q;
  assign clk_reg = clkr_q;
  assign wr_sel  = comm_q[SEL_HI:SEL_LO];
endmodule

// File: rtl/csp_ready_ctrl.sv
module csp_ready_ctrl #(
  parameter int DATA_W       = 16,
  parameter int BLANK_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  input  logic [DATA_W-1:0] result,
  input  logic              cal_done,
  input  logic              rd_done,
  output logic              drdy_n,
  output logic [DATA_W-1:0] data_q,
  output logic              load_ev,
  output logic              blank_act
);
  localparam int BW = $clog2(BLANK_CYCLES + 1);

  logic              drdy_q, drdy_d;
  logic              blank_q, blank_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic [DATA_W-1:0] pend_q, pend_d, data_d;
  logic              blank_go;

  always_comb begin
    load_ev  = 1'b0;
    blank_go = 1'b0;
    blank_d  = blank_q;
    bcnt_d   = bcnt_q;
    pend_d   = upd_stb ? result : pend_q;
    data_d   = data_q;
    if (blank_q) begin
      if (bcnt_q == '0) begin
        load_ev = 1'b1;
        data_d  = upd_stb ? result : pend_q;
        blank_d = 1'b0;
      end else begin
        bcnt_d = bcnt_q - BW'(1);
      end
    end else if (upd_stb) begin
      if (!drdy_q) begin
        blank_go = 1'b1;
        blank_d  = 1'b1;
        bcnt_d   = BW'(BLANK_CYCLES - 1);
      end else begin
        load_ev = 1'b1;
        data_d  = result;
      end
    end
    if (load_ev)                  drdy_d = 1'b0;
    else if (blank_go || blank_q) drdy_d = 1'b1;
    else if (rd_done)             drdy_d = 1'b1;
    else if (cal_done)            drdy_d = 1'b0;
    else                          drdy_d = drdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q  <= 1'b1;
      blank_q <= 1'b0;
      bcnt_q  <= '0;
      pend_q  <= '0;
      data_q  <= '0;
    end else begin
      drdy_q  <= drdy_d;
      blank_q <= blank_d;
      bcnt_q  <= bcnt_d;
      pend_q  <= pend_d;
      data_q  <= data_d;
    end
  end

  assign drdy_n    = drdy_q;
  assign blank_act = blank_q;
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import csp_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int REG_W        = 8,
  parameter int BLANK_CYCLES = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              drdy_n,
  input  logic [DATA_W-1:0] result,
  input  logic              result_stb,
  input  logic              cal_done,
  output logic [REG_W-1:0]  setup_cfg,
  output logic              clk_out_off,
  output logic [2:0]        rate_sel
);
  logic [1:0]        rst_sr;
  logic              rst_int;
  logic              sclk_rise, sclk_fall, cs_idle;
  logic [DATA_W-1:0] data_q;
  logic [REG_W-1:0]  clk_reg;
  logic              wr_stb, rd_done, load_ev, blank_act;
  logic [1:0]        wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_int = rst_sr[1];

  csp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .sclk(sclk), .cs_n(cs_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_idle(cs_idle)
  );

  csp_shifter #(.DATA_W(DATA_W), .REG_W(REG_W)) u_shift (
    .clk(clk), .rst_n(rst_int), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .din(din), .data_word(data_q), .dout(dout),
    .setup_q(setup_cfg), .clk_reg(clk_reg), .wr_stb(wr_stb),
    .wr_sel(wr_sel), .rd_done(rd_done)
  );

  csp_ready_ctrl #(.DATA_W(DATA_W), .BLANK_CYCLES(BLANK_CYCLES)) u_rdy (
    .clk(clk), .rst_n(rst_int), .upd_stb(result_stb), .result(result),
    .cal_done(cal_done), .rd_done(rd_done), .drdy_n(drdy_n),
    .data_q(data_q), .load_ev(load_ev), .blank_act(blank_act)
  );

  assign clk_out_off = clk_reg[CLKOFF_BIT];
  assign rate_sel    = clk_reg[RATE_W-1:0];
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_fall,
  input logic              dout,
  input logic              drdy_n,
  input logic [DATA_W-1:0] data_q,
  input logic              load_ev,
  input logic              blank_act,
  input logic              rd_done,
  input logic              cal_done,
  input logic              wr_stb,
  input logic [1:0]        wr_sel,
  input logic [REG_W-1:0]  clk_reg
);
  AST_DOUT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(sclk_fall)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_n |-> $stable(data_q)); // R6
  AST_BLANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    blank_act |-> drdy_n); // R7
  AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(load_ev || cal_done)); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !load_ev) |=> drdy_n); // R6
  AST_CLKREG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_sel == 2'd2) |=> $stable(clk_reg)); // R2
endmodule

bind conv_serial_port csp_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_int), .sclk_fall(sclk_fall), .dout(dout),
  .drdy_n(drdy_n), .data_q(data_q), .load_ev(load_ev), .blank_act(blank_act),
  .rd_done(rd_done), .cal_done(cal_done), .wr_stb(wr_stb), .wr_sel(wr_sel),
  .clk_reg(clk_reg)
);

// File: tb/conv_serial_port_tb.sv
module conv_serial_port_tb;
  logic        clk = 1'b0;
  logic        rst_n, sclk, cs_n, din, result_stb, cal_done;
  logic        dout, drdy_n, clk_out_off;
  logic [15:0] result;
  logic [7:0]  setup_cfg;
  logic [2:0]  rate_sel;
  int          tests = 0, failed = 0, r9_bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  conv_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .drdy_n(drdy_n), .result(result), .result_stb(result_stb),
    .cal_done(cal_done), .setup_cfg(setup_cfg), .clk_out_off(clk_out_off),
    .rate_sel(rate_sel)
  );

  // entries: {select[1:0], value[7:0]}
  localparam logic [9:0] VEC [4] = '{
    {2'd1, 8'hA5}, {2'd2, 8'h13}, {2'd1, 8'h3C}, {2'd2, 8'h05}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift(input int n, input logic [15:0] wv, output logic [15:0] rd);
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 1'b0; din = wv[i];
      repeat (5) @(negedge clk);
      rd[i] = dout;
      sclk = 1'b1;
      repeat (5) @(negedge clk);
      if (dout !== rd[i]) r9_bad++;
    end
  endtask

  function automatic logic [15:0] cmd(input logic [1:0] sel, input logic rd);
    return {8'h00, 2'b00, sel, rd, 3'b000};
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] v);
    logic [15:0] d;
    shift(8, cmd(sel, 1'b0), d);
    shift(8, {8'h00, v}, d);
  endtask

  task automatic rd_reg(input logic [1:0] sel, input int n, output logic [15:0] o);
    logic [15:0] d;
    shift(8, cmd(sel, 1'b1), d);
    shift(n, 16'h0000, o);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    sclk = 1'b1; cs_n = 1'b0; din = 1'b0;
    result = '0; result_stb = 1'b0; cal_done = 1'b0;
    do_reset();
    // R11 reset state
    chk("R11 drdy_n", {15'd0, drdy_n}, 16'd1);
    chk("R11 dout", {15'd0, dout}, 16'd0);
    chk("R11 setup", {8'd0, setup_cfg}, 16'd0);
    chk("R11 clkfields", {12'd0, clk_out_off, rate_sel}, 16'd0);

    // R2 R3 vector walk
    for (int v = 0; v < 4; v++) begin
      wr_reg(VEC[v][9:8], VEC[v][7:0]);
      rd_reg(VEC[v][9:8], 8, rv);
      chk("R2 readback", rv, {8'h00, VEC[v][7:0]});
      if (VEC[v][9:8] == 2'd2)
        chk("R3 clock fields", {12'd0, clk_out_off, rate_sel},
            {12'd0, VEC[v][4], VEC[v][2:0]});
      else
        chk("R3 setup out", {8'd0, setup_cfg}, {8'd0, VEC[v][7:0]});
    end

    // R1 command register read returns the command byte
    rd_reg(2'd0, 8, rv);
    chk("R1 comm read", rv, 16'h0008);

    // R5 fresh result while idle
    @(negedge clk); result = 16'hBEEF; result_stb = 1'b1;
    @(negedge clk); result_stb = 1'b0;
    @(negedge clk);
    chk("R5 drdy low", {15'd0, drdy_n}, 16'd0);
    rd_reg(2'd3, 16, rv);
    chk("R6 data read", rv, 16'hBEEF);
    chk("R6 drdy released", {15'd0, drdy_n}, 16'd1);
    rd_reg(2'd3, 16, rv);
    chk("R6 reread", rv, 16'hBEEF);

    // R8 calibration done
    @(negedge clk); cal_done = 1'b1;
    @(negedge clk); cal_done = 1'b0;
    @(negedge clk);
    chk("R8 drdy low", {15'd0, drdy_n}, 16'd0);
    rd_reg(2'd3, 16, rv);
    chk("R8 data kept", rv, 16'hBEEF);

    // R7 unread update blanking
    @(negedge clk); result = 16'h1234; result_stb = 1'b1;
    @(negedge clk); result_stb = 1'b0;
    @(negedge clk);
    chk("R5 second load", {15'd0, drdy_n}, 16'd0);
    begin
      int hi_cnt = 0;
      fork
        begin
          result = 16'h5678; result_stb = 1'b1;
          @(negedge clk); result_stb = 1'b0;
          while (drdy_n === 1'b1 && hi_cnt < 2000) begin
            hi_cnt++;
            @(negedge clk);
          end
        end
        begin
          logic [15:0] w;
          rd_reg(2'd3, 16, w);
          chk("R7 old word in window", w, 16'h1234);
          chk("R7 still blanked", {15'd0, drdy_n}, 16'd1);
        end
      join
      chk("R7 window length", hi_cnt[15:0], 16'd500);
    end
    rd_reg(2'd3, 16, rv);
    chk("R7 new word", rv, 16'h5678);

    // R4 write to result register is discarded
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd3, 16, rv);
    chk("R4 result unchanged", rv, 16'h5678);
    rd_reg(2'd1, 8, rv);
    chk("R4 next byte is command", rv, 16'h003C);

    // R10 select raised mid transfer
    shift(8, cmd(2'd1, 1'b0), rv);
    shift(3, 16'h0007, rv);
    @(negedge clk); cs_n = 1'b1;
    repeat (10) @(negedge clk);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 setup untouched", {8'd0, setup_cfg}, 16'h003C);
    rd_reg(2'd1, 8, rv);
    chk("R10 command after abort", rv, 16'h003C);

    // R9 data-out never moved during a high serial-clock phase
    chk("R9 dout stable on rise", r9_bad[15:0], 16'd0);

    // R11 reset after activity
    do_reset();
    chk("R11 setup cleared", {8'd0, setup_cfg}, 16'd0);
    chk("R11 drdy after reset", {15'd0, drdy_n}, 16'd1);
    rd_reg(2'd3, 16, rv);
    chk("R11 result cleared", rv, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule